// File: doc/BRIEF.md
# Indexed Display-Mode Register File

This block holds the extended display-mode settings of a graphics adapter behind a two-location host port. Writing the index location picks a register. Accesses to the data location then read or write that register. Every data write is checked against the rules of its target register. A value that breaks those rules is discarded and the register keeps its old contents.

Setting the enable bit in the control register starts a mode switch, carried out in one cycle in hardware. The virtual canvas takes the current resolution and both panning offsets go back to zero. The bytes per scanline are computed from the width and colour depth, and the start address returns to zero. Unless the write suppresses it, a one-cycle request goes out to clear the framebuffer, and it carries the number of bytes to clear. A downstream display pipeline reads the resolution, depth, enable and linear flags, scanline pitch and start address straight from the outputs.

Top module: `disp_mode_regs`

## Requirements
- R1: `addr_sel` low selects the index location and high selects the data location. A write with `addr_sel` low stores all 16 bits of `wdata` as the index. A read with `addr_sel` low returns that index on `rdata`, combinationally.
- R2: Indices 0 to 9 are valid: 0 identity, 1 width, 2 height, 3 colour depth, 4 control, 5 bank, 6 virtual width, 7 virtual height, 8 horizontal offset, 9 vertical offset. A data read at index 10 or above returns 0, and a data write there changes no register.
- R3: The identity register resets to 0xB0C0. Only a write of 0xB0C0, 0xB0C1 or 0xB0C2 to it is stored.
- R4: A width write is stored only if the value is at most 1024 and a multiple of 8.
- R5: A height write is stored only if the value is at most 768.
- R6: A colour-depth write of 0 is stored as 8. After that substitution, only 4, 8, 15, 16, 24 and 32 are stored.
- R7: A bank write stores only its low 8 bits, and the upper bits read back as 0.
- R8: A control write with bit 0 set also does the following on the same clock edge: it copies width and height into the virtual width and height and zeroes both offsets. It sets `start_addr` to 0. It sets `line_offset` to width/2 at depth 4, and otherwise to width × ((depth+7)/8), using the width and depth held before the write.
- R9: A control write with bit 0 set and bit 7 clear makes `clr_req` high for exactly the following cycle, with `clr_bytes` equal to height × the new line offset. With bit 7 set, or with bit 0 clear, no request is made.
- R10: A control write always stores its value. `disp_en` shows control bit 0 and `disp_linear` shows control bit 6. Writes to registers 6 to 9 and a control write with bit 0 clear are stored unchecked and leave `line_offset` unchanged.
- R11: After reset, the index and every register other than the identity register are 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 1 | 0 = index location, 1 = data location |
| wr_en | input | 1 | Write strobe for the selected location |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected location |
| disp_xres | output | 16 | Current width |
| disp_yres | output | 16 | Current height |
| disp_bpp | output | 16 | Current colour depth |
| disp_en | output | 1 | Mode enable (control bit 0) |
| disp_linear | output | 1 | Linear framebuffer flag (control bit 6) |
| line_offset | output | 32 | Bytes per scanline |
| start_addr | output | 32 | Display start address |
| clr_req | output | 1 | One-cycle framebuffer clear request |
| clr_bytes | output | 32 | Byte count of the clear request |

## Verification
The directed cases test each validation rule at its boundary: the largest accepted width or height against one step beyond it, a width that is not a multiple of 8, the depth-0 substitution, an unlisted depth, and each accepted and rejected identity code. Mode enables are tried at depth 4 and at multi-byte depths, and with the clear both allowed and suppressed. These cases separate the halving rule from the multiply rule and show that the pulse carries the new pitch. A seeded random phase mixes index writes, including out-of-range indices, with data values drawn from the legal and illegal pools of each register. It compares a full read-back and the exported outputs against a bench model, which exposes any rule that lets a bad value through or damages a neighbouring register.

// File: rtl/disp_mode_regs.sv
module disp_mode_regs #(
  parameter int DW = 16,
  parameter int AW = 32,
  parameter int NREG = 10,
  parameter int MAX_X = 1024,
  parameter int MAX_Y = 768,
  parameter logic [15:0] ID_BASE = 16'hB0C0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] disp_xres,
  output logic [DW-1:0] disp_yres,
  output logic [DW-1:0] disp_bpp,
  output logic          disp_en,
  output logic          disp_linear,
  output logic [AW-1:0] line_offset,
  output logic [AW-1:0] start_addr,
  output logic          clr_req,
  output logic [AW-1:0] clr_bytes
);
  localparam int R_ID = 0, R_XR = 1, R_YR = 2, R_BPP = 3, R_CTL = 4, R_BANK = 5;
  localparam int R_VW = 6, R_VH = 7, R_XO = 8, R_YO = 9;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] idx_q;
  logic [DW-1:0] wval, bpp_eff, rd_mux;
  logic          accept;
  logic [AW-1:0] lo_next;

  wire data_wr = wr_en & addr_sel;
  wire idx_ok  = idx_q < DW'(NREG);
  wire mode_on = data_wr && idx_q == DW'(R_CTL) && wdata[0];

  assign bpp_eff = (wdata == '0) ? DW'(8) : wdata;

  always_comb begin
    accept = 1'b1;
    wval   = wdata;
    case (idx_q)
      DW'(R_ID):  accept = (wdata == DW'(ID_BASE)) || (wdata == DW'(ID_BASE + 16'd1)) ||
                           (wdata == DW'(ID_BASE + 16'd2));
      DW'(R_XR):  accept = (wdata <= DW'(MAX_X)) && (wdata[2:0] == 3'd0);
      DW'(R_YR):  accept = (wdata <= DW'(MAX_Y));
      DW'(R_BPP): begin
        wval   = bpp_eff;
        accept = (bpp_eff == DW'(4))  || (bpp_eff == DW'(8))  || (bpp_eff == DW'(15)) ||
                 (bpp_eff == DW'(16)) || (bpp_eff == DW'(24)) || (bpp_eff == DW'(32));
      end
      DW'(R_BANK): wval = wdata & DW'(8'hFF);
      default: ;
    endcase
  end

  assign lo_next = (regs[R_BPP] == DW'(4)) ? AW'(regs[R_XR] >> 1)
                 : AW'(regs[R_XR]) * AW'((regs[R_BPP] + DW'(7)) >> 3);

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (idx_q == DW'(i)) rd_mux = regs[i];
  end

  assign rdata = !addr_sel ? idx_q : (idx_ok ? rd_mux : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      for (int i = 0; i < NREG; i++) regs[i] <= (i == R_ID) ? DW'(ID_BASE) : '0;
      line_offset <= '0;
      start_addr  <= '0;
      clr_req     <= 1'b0;
      clr_bytes   <= '0;
    end else begin
      clr_req <= 1'b0;
      if (wr_en && !addr_sel) idx_q <= wdata;
      if (data_wr && idx_ok && accept)
        for (int i = 0; i < NREG; i++)
          if (idx_q == DW'(i)) regs[i] <= wval;
      if (mode_on) begin
        regs[R_VW]  <= regs[R_XR];
        regs[R_VH]  <= regs[R_YR];
        regs[R_XO]  <= '0;
        regs[R_YO]  <= '0;
        line_offset <= lo_next;
        start_addr  <= '0;
        if (!wdata[7]) begin
          clr_req   <= 1'b1;
          clr_bytes <= AW'(regs[R_YR]) * lo_next;
        end
      end
    end
  end

  assign disp_xres   = regs[R_XR];
  assign disp_yres   = regs[R_YR];
  assign disp_bpp    = regs[R_BPP];
  assign disp_en     = regs[R_CTL][0];
  assign disp_linear = regs[R_CTL][6];
endmodule

module disp_mode_regs_chk #(
  parameter int DW = 16,
  parameter int NREG = 10,
  parameter int MAX_X = 1024,
  parameter int MAX_Y = 768,
  parameter logic [15:0] ID_BASE = 16'hB0C0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_sel,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] idx,
  input logic [DW-1:0] id,
  input logic [DW-1:0] xres,
  input logic [DW-1:0] yres,
  input logic [DW-1:0] bpp,
  input logic [DW-1:0] bank,
  input logic [DW-1:0] virt_w,
  input logic [DW-1:0] x_off,
  input logic [DW-1:0] y_off,
  input logic          clr_req
);
  wire dw = rst_n && wr_en && addr_sel;

  assert_oob_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && idx >= DW'(NREG)) |=> ($stable(xres) && $stable(yres) && $stable(bpp)));
  assert_id_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (id == DW'(ID_BASE)) || (id == DW'(ID_BASE + 16'd1)) || (id == DW'(ID_BASE + 16'd2)));
  assert_xres_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && idx == DW'(1) && (wdata > DW'(MAX_X) || wdata[2:0] != 3'd0)) |=> $stable(xres));
  assert_yres_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && idx == DW'(2) && wdata > DW'(MAX_Y)) |=> $stable(yres));
  assert_bpp_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bpp == 0) || (bpp == 4) || (bpp == 8) || (bpp == 15) || (bpp == 16) || (bpp == 24) || (bpp == 32));
  assert_bank_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bank[DW-1:8] == '0);
  assert_enable_geom_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dw && idx == DW'(4) && wdata[0]) |=> (virt_w == $past(xres) && x_off == '0 && y_off == '0));
  assert_clear_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |-> $past(dw && idx == DW'(4) && wdata[0] && !wdata[7]));
endmodule

bind disp_mode_regs disp_mode_regs_chk #(.DW(DW), .NREG(NREG), .MAX_X(MAX_X), .MAX_Y(MAX_Y), .ID_BASE(ID_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en), .wdata(wdata),
  .idx(idx_q), .id(regs[0]), .xres(regs[1]), .yres(regs[2]), .bpp(regs[3]),
  .bank(regs[5]), .virt_w(regs[6]), .x_off(regs[8]), .y_off(regs[9]), .clr_req(clr_req));

// File: tb/sim_disp_mode_regs.sv
module sim_disp_mode_regs;
  logic clk = 0, rst_n = 0, addr_sel = 0, wr_en = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata, disp_xres, disp_yres, disp_bpp;
  logic disp_en, disp_linear, clr_req;
  logic [31:0] line_offset, start_addr, clr_bytes;

  int checks = 0, fails = 0;
  bit done = 0;
  int unsigned m_regs [10];
  int unsigned m_idx = 0, m_lo = 0;

  always #5 clk = ~clk;

  disp_mode_regs u0 (.clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .disp_xres(disp_xres), .disp_yres(disp_yres), .disp_bpp(disp_bpp),
    .disp_en(disp_en), .disp_linear(disp_linear), .line_offset(line_offset),
    .start_addr(start_addr), .clr_req(clr_req), .clr_bytes(clr_bytes));

  task automatic chk(string req, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic bit legal_bpp(int unsigned b);
    return b == 4 || b == 8 || b == 15 || b == 16 || b == 24 || b == 32;
  endfunction

  function automatic int unsigned pitch(int unsigned x, int unsigned b);
    return (b == 4) ? x / 2 : x * ((b + 7) / 8);
  endfunction

  task automatic wr(bit a, int unsigned d);
    bit exp_clr = 0;
    int unsigned exp_bytes = 0, v = d & 16'hFFFF;
    @(negedge clk);
    addr_sel = a; wr_en = 1; wdata = 16'(v);
    if (!a) m_idx = v;
    else if (m_idx < 10) begin
      case (m_idx)
        0: if (v >= 16'hB0C0 && v <= 16'hB0C2) m_regs[0] = v;
        1: if (v <= 1024 && v % 8 == 0) m_regs[1] = v;
        2: if (v <= 768) m_regs[2] = v;
        3: begin if (v == 0) v = 8; if (legal_bpp(v)) m_regs[3] = v; end
        4: begin
          if (v[0]) begin
            m_lo = pitch(m_regs[1], m_regs[3]);
            m_regs[6] = m_regs[1]; m_regs[7] = m_regs[2]; m_regs[8] = 0; m_regs[9] = 0;
            if (!v[7]) begin exp_clr = 1; exp_bytes = m_regs[2] * m_lo; end
          end
          m_regs[4] = v;
        end
        5: m_regs[5] = v & 8'hFF;
        default: m_regs[m_idx] = v;
      endcase
    end
    @(negedge clk);
    wr_en = 0;
    chk("R9 clr_req", clr_req, exp_clr);
    if (exp_clr) chk("R9 clr_bytes", clr_bytes, exp_bytes);
  endtask

  task automatic rd(bit a, output logic [15:0] q);
    addr_sel = a; wr_en = 0;
    #1 q = rdata;
  endtask

  task automatic verify_all(string tag);
    logic [15:0] q;
    for (int i = 0; i < 10; i++) begin
      wr(0, i);
      rd(0, q); chk({tag, " R1 index"}, q, i);
      rd(1, q); chk($sformatf("%s R2 reg%0d", tag, i), q, m_regs[i]);
    end
    chk({tag, " R10 xres"}, disp_xres, m_regs[1]);
    chk({tag, " R10 yres"}, disp_yres, m_regs[2]);
    chk({tag, " R10 bpp"}, disp_bpp, m_regs[3]);
    chk({tag, " R10 en"}, disp_en, m_regs[4] & 1);
    chk({tag, " R10 linear"}, disp_linear, (m_regs[4] >> 6) & 1);
    chk({tag, " R8 line_offset"}, line_offset, m_lo);
    chk({tag, " R8 start_addr"}, start_addr, 0);
  endtask

  task automatic set(int unsigned i, int unsigned v);
    wr(0, i); wr(1, v);
  endtask

  initial begin
    logic [15:0] q;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 10; i++) m_regs[i] = 0;
    m_regs[0] = 16'hB0C0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    rd(0, q); chk("R11 index reset", q, 0);
    chk("R11 clr_req reset", clr_req, 0);
    chk("R11 line_offset reset", line_offset, 0);
    chk("R11 disp_en reset", disp_en, 0);
    verify_all("R11 reset");
    rd(1, q); chk("R3 id reset", {16'h0, q}, 0); // index is 9 here: offset reg
    wr(0, 0); rd(1, q); chk("R3 id reset value", q, 16'hB0C0);

    // R3 identity codes
    set(0, 16'hB0C3); set(0, 16'h1234); set(0, 16'hB0C2);
    wr(0, 0); rd(1, q); chk("R3 id accepted", q, 16'hB0C2);
    // R4 width boundaries
    set(1, 1032); set(1, 1020); set(1, 1024);
    chk("R4 max width", disp_xres, 1024);
    set(1, 1028); chk("R4 width over", disp_xres, 1024);
    set(1, 640); chk("R4 width 640", disp_xres, 640);
    // R5 height
    set(2, 769); chk("R5 height over", disp_yres, 0);
    set(2, 768); chk("R5 height max", disp_yres, 768);
    set(2, 480);
    // R6 depth
    set(3, 0); chk("R6 depth zero->8", disp_bpp, 8);
    set(3, 7); chk("R6 depth 7 rejected", disp_bpp, 8);
    set(3, 24); chk("R6 depth 24", disp_bpp, 24);
    // R7 bank
    set(5, 16'h1234); wr(0, 5); rd(1, q); chk("R7 bank low byte", q, 16'h34);
    // R2 out of range
    set(10, 16'h5555); set(16'hFFFF, 16'h7777);
    rd(1, q); chk("R2 out-of-range read", q, 0);
    set(8, 12); set(9, 34);
    // R8/R9 enable with clear, linear
    set(4, 16'h41);
    chk("R8 pitch 24bpp", line_offset, 1920);
    chk("R10 linear flag", disp_linear, 1);
    verify_all("R8 enable");
    // R9 no clear when suppressed, depth 4 halving
    set(3, 4); set(1, 800); set(4, 16'h81);
    chk("R8 pitch 4bpp", line_offset, 400);
    // R10 enable bit 0 clear keeps pitch
    set(3, 32); set(4, 16'h40);
    chk("R10 pitch held", line_offset, 400);
    chk("R10 disabled", disp_en, 0);
    set(4, 16'h01);
    chk("R8 pitch 32bpp", line_offset, 3200);
    verify_all("directed");

    // random phase
    for (int n = 0; n < 600; n++) begin
      int unsigned i = $urandom % 12, v;
      case (i)
        0: v = 16'hB0BF + $urandom % 5;
        1: v = ($urandom % 2) ? ($urandom % 129) * 8 : $urandom % 1100;
        2: v = 760 + $urandom % 16;
        3: v = $urandom % 34;
        4: v = {$urandom % 2, 1'b0, $urandom % 2, 5'b0, $urandom % 2};
        default: v = $urandom % 65536;
      endcase
      set(i, v);
      if (n % 40 == 39) verify_all("random");
    end
    verify_all("final");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule